// File: doc/BRIEF.md
# Programmable Clock Synthesizer Divider Chain

This block holds the digital dividers that sit around the oscillator of a frequency synthesizer. A pre-divider reduces the reference clock before phase comparison. A main divider in the feedback path reduces the oscillator clock. A post scaler divides the oscillator clock by a power of two to form the final output clock. Once the loop has locked, the output frequency is the reference frequency times (M+8) / ((P+2) * 2^S).

The three divide fields form one 16-bit control word. A holding register supplies the word, and it is written through a write-enable port. For test, any single bit of the word can be replaced by an external test pin through a per-bit bypass multiplexer. Each counter takes new settings only at its own terminal count, so a divided output never produces a shortened pulse. A power-down input stops all three dividers and holds their outputs low.

Top module: `clk_synth_div_chain`

## Requirements
- R1: The control word is laid out as main field [15:8], pre field [7:2] and post field [1:0]. The holding register is written on a rising edge of `vco_clk_i` while `cfg_we_i` is high, and it resets to all zeros.
- R2: `fb_div_o` has a period of M+8 cycles of `vco_clk_i`, where M is the main field.
- R3: `ref_div_o` has a period of P+2 cycles of `ref_clk_i`, where P is the pre field.
- R4: For S from 1 to 3, `clk_o` has a period of 2^S cycles of `vco_clk_i`, and it is high for the first half of each period. For S = 0, `clk_o` follows `vco_clk_i`: high in the high phase and low in the low phase.
- R5: For a ratio n, each period of `ref_div_o` and `fb_div_o` is high for floor(n/2) cycles and then low for the remaining cycles, so the low phase is equal to the high phase or one cycle longer.
- R6: A new ratio takes effect only at the counter's terminal count. A period already in progress completes with the old ratio, and the next period uses the new one.
- R7: Each bit whose `test_sel_i` bit is 1 takes its value from `test_word_i` instead of the register. Clearing `test_sel_i` restores the register value, which the bypass leaves unchanged.
- R8: While `pwrdn_i` is high, all three outputs are low from the next clock edge on. After release, every output rises at the first edge, and the first period has its full length.
- R9: During reset all outputs are low. After reset the ratios are 8 (main), 2 (pre) and 1 (post).
- R10: The extreme fields M = 255 and P = 63 give periods of 263 and 65 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk_i | input | 1 | Oscillator clock; clocks the main divider, post scaler and register |
| ref_clk_i | input | 1 | Reference clock; clocks the pre-divider |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwrdn_i | input | 1 | Power-down; stops the dividers and forces the outputs low |
| cfg_we_i | input | 1 | Write enable of the holding register |
| cfg_wdata_i | input | 16 | Control word to write |
| test_sel_i | input | 16 | Per-bit bypass select |
| test_word_i | input | 16 | Bypass values from the test pins |
| ref_div_o | output | 1 | Divided reference |
| fb_div_o | output | 1 | Divided oscillator clock for the feedback path |
| clk_o | output | 1 | Scaled output clock |

## Verification
A corrupted counter or latched ratio shows up as a wrong period or duty on its own output, and it is visible no later than the end of the next full period. The worst case is 263 oscillator cycles on the feedback output. A ratio that is picked up at the wrong moment shows up as a period of mixed length right after the write. The bench measures that period directly. A power-down or reset path that fails to clear the state shows up at the first edge after release, as a missing rise or a truncated first period.

// File: rtl/clk_div_pkg.sv
package clk_div_pkg;
  localparam int MAIN_W   = 8;
  localparam int PRE_W    = 6;
  localparam int POST_W   = 2;
  localparam int MAIN_OFS = 8;
  localparam int PRE_OFS  = 2;
  localparam int WORD_W   = MAIN_W + PRE_W + POST_W;

  typedef struct packed {
    logic [MAIN_W-1:0] main;
    logic [PRE_W-1:0]  pre;
    logic [POST_W-1:0] post;
  } div_word_t;
endpackage

// File: rtl/div_cfg_sel.sv
module div_cfg_sel #(
  parameter int WW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [WW-1:0] wdata_i,
  input  logic [WW-1:0] test_sel_i,
  input  logic [WW-1:0] test_word_i,
  output logic [WW-1:0] word_o
);
  logic [WW-1:0] reg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   reg_q <= '0;
    else if (we_i) reg_q <= wdata_i;
  end

  for (genvar b = 0; b < WW; b++) begin : g_byp
    assign word_o[b] = test_sel_i[b] ? test_word_i[b] : reg_q[b];
  end
endmodule

// File: rtl/ofs_div.sv
// Divide by field+OFS; high for floor(n/2) cycles, ratio latched at terminal count.
module ofs_div #(
  parameter int FW  = 8,
  parameter int OFS = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pd_i,
  input  logic [FW-1:0] field_i,
  output logic          div_o
);
  localparam int RW = $clog2((2**FW) + OFS);

  logic [RW-1:0] cnt_q, cnt_d, rat_q, rat_d, rat_new;
  logic          tc, out_q, out_d;

  assign rat_new = RW'(field_i) + RW'(OFS);
  assign tc      = (cnt_q == rat_q - RW'(1));

  always_comb begin
    if (pd_i) begin
      rat_d = rat_new;
      cnt_d = rat_new - RW'(1);  // park at terminal: full first period on release
    end else if (tc) begin
      rat_d = rat_new;
      cnt_d = '0;
    end else begin
      rat_d = rat_q;
      cnt_d = cnt_q + RW'(1);
    end
    out_d = !pd_i && (cnt_d < (rat_d >> 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= RW'(OFS - 1);
      rat_q <= RW'(OFS);
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rat_q <= rat_d;
      out_q <= out_d;
    end
  end

  assign div_o = out_q;
endmodule

// File: rtl/pow2_scaler.sv
// Divide by 2**field; field 0 passes the gated clock.
module pow2_scaler #(
  parameter int SW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pd_i,
  input  logic [SW-1:0] field_i,
  output logic          clk_o
);
  localparam int CW = (2**SW) - 1;

  logic [SW-1:0] s_q, s_d, idx;
  logic [CW-1:0] cnt_q, cnt_d, mask, sh;
  logic [CW:0]   mask_w;
  logic          tc, div_bit, gate_q;

  assign mask_w  = ((CW+1)'(1) << s_q) - (CW+1)'(1);
  assign mask    = mask_w[CW-1:0];
  assign tc      = ((cnt_q & mask) == mask);
  assign idx     = (s_q == '0) ? '0 : s_q - SW'(1);
  assign sh      = cnt_q >> idx;
  assign div_bit = ~sh[0];

  always_comb begin
    if (pd_i) begin
      s_d   = field_i;
      cnt_d = '1;
    end else if (tc) begin
      s_d   = field_i;
      cnt_d = '0;
    end else begin
      s_d   = s_q;
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q   <= '0;
      cnt_q <= '1;
    end else begin
      s_q   <= s_d;
      cnt_q <= cnt_d;
    end
  end

  // enable changes in the low phase only
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= ~pd_i;
  end

  assign clk_o = (s_q == '0) ? (clk_i & gate_q) : div_bit;
endmodule

// File: rtl/clk_synth_div_chain.sv
module clk_synth_div_chain
  import clk_div_pkg::*;
(
  input  logic              vco_clk_i,
  input  logic              ref_clk_i,
  input  logic              rst_ni,
  input  logic              pwrdn_i,
  input  logic              cfg_we_i,
  input  logic [WORD_W-1:0] cfg_wdata_i,
  input  logic [WORD_W-1:0] test_sel_i,
  input  logic [WORD_W-1:0] test_word_i,
  output logic              ref_div_o,
  output logic              fb_div_o,
  output logic              clk_o
);
  logic [WORD_W-1:0] word;
  div_word_t         cfg;

  div_cfg_sel #(.WW(WORD_W)) u_cfg (
    .clk_i      (vco_clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .wdata_i    (cfg_wdata_i),
    .test_sel_i (test_sel_i),
    .test_word_i(test_word_i),
    .word_o     (word)
  );

  assign cfg = div_word_t'(word);

  ofs_div #(.FW(PRE_W), .OFS(PRE_OFS)) u_pre (
    .clk_i  (ref_clk_i),
    .rst_ni (rst_ni),
    .pd_i   (pwrdn_i),
    .field_i(cfg.pre),
    .div_o  (ref_div_o)
  );

  ofs_div #(.FW(MAIN_W), .OFS(MAIN_OFS)) u_main (
    .clk_i  (vco_clk_i),
    .rst_ni (rst_ni),
    .pd_i   (pwrdn_i),
    .field_i(cfg.main),
    .div_o  (fb_div_o)
  );

  pow2_scaler #(.SW(POST_W)) u_post (
    .clk_i  (vco_clk_i),
    .rst_ni (rst_ni),
    .pd_i   (pwrdn_i),
    .field_i(cfg.post),
    .clk_o  (clk_o)
  );
endmodule

// File: rtl/clk_synth_div_chain_chk.sv
module div_duty_mon #(
  parameter int W      = 16,
  parameter int MAX_HI = 131
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pd_i,
  input logic sig_i
);
  logic         prv_q, seen_q;
  logic [W-1:0] hi_q, lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prv_q  <= 1'b0;
      seen_q <= 1'b0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else begin
      prv_q <= sig_i;
      if (pd_i)       seen_q <= 1'b0;
      else if (sig_i) seen_q <= 1'b1;
      if (sig_i) begin
        hi_q <= prv_q ? hi_q + W'(1) : W'(1);
        lo_q <= '0;
      end else if (lo_q != '1) begin
        lo_q <= lo_q + W'(1);
      end
    end
  end

  assert_duty_split_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sig_i && !prv_q && seen_q) |-> (lo_q == hi_q || lo_q == hi_q + W'(1)));

  assert_high_run_max_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sig_i && prv_q) |-> (hi_q < W'(MAX_HI)));
endmodule

module clk_synth_div_chain_chk
  import clk_div_pkg::*;
(
  input logic vco_clk_i,
  input logic ref_clk_i,
  input logic rst_ni,
  input logic pwrdn_i,
  input logic ref_div_o,
  input logic fb_div_o,
  input logic clk_o
);
  div_duty_mon #(.W(16), .MAX_HI(((2**MAIN_W) + MAIN_OFS - 1) / 2)) u_fb_mon (
    .clk_i(vco_clk_i), .rst_ni(rst_ni), .pd_i(pwrdn_i), .sig_i(fb_div_o));

  div_duty_mon #(.W(16), .MAX_HI(((2**PRE_W) + PRE_OFS - 1) / 2)) u_ref_mon (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .pd_i(pwrdn_i), .sig_i(ref_div_o));

  assert_pd_vco_low_R8: assert property (@(posedge vco_clk_i) disable iff (!rst_ni)
    pwrdn_i |=> (!fb_div_o && !clk_o));

  assert_pd_ref_low_R8: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    pwrdn_i |=> !ref_div_o);
endmodule

bind clk_synth_div_chain clk_synth_div_chain_chk u_chk (
  .vco_clk_i(vco_clk_i),
  .ref_clk_i(ref_clk_i),
  .rst_ni   (rst_ni),
  .pwrdn_i  (pwrdn_i),
  .ref_div_o(ref_div_o),
  .fb_div_o (fb_div_o),
  .clk_o    (clk_o)
);

// File: tb/clk_synth_div_chain_bench.sv
module clk_synth_div_chain_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwrdn = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] test_sel = '0;
  logic [15:0] test_word = '0;
  logic        ref_div, fb_div, clk_out;
  int          n_chk = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  clk_synth_div_chain u_clk_synth_div_chain (
    .vco_clk_i  (clk),
    .ref_clk_i  (clk),
    .rst_ni     (rst_n),
    .pwrdn_i    (pwrdn),
    .cfg_we_i   (cfg_we),
    .cfg_wdata_i(cfg_wdata),
    .test_sel_i (test_sel),
    .test_word_i(test_word),
    .ref_div_o  (ref_div),
    .fb_div_o   (fb_div),
    .clk_o      (clk_out)
  );

  // {main, pre, post}
  localparam int NV = 8;
  localparam logic [15:0] VEC [NV] = '{
    {8'd0,   6'd0,  2'd0},
    {8'd1,   6'd1,  2'd1},
    {8'd85,  6'd42, 2'd0},
    {8'd255, 6'd63, 2'd3},
    {8'd2,   6'd5,  2'd2},
    {8'd7,   6'd0,  2'd1},
    {8'd100, 6'd30, 2'd3},
    {8'd254, 6'd62, 2'd2}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic pick(input int w);
    case (w)
      0:       return ref_div;
      1:       return fb_div;
      default: return clk_out;
    endcase
  endfunction

  task automatic meas(input int w, input bit aligned, output int hi, output int per);
    logic prv, cur;
    int   g;
    hi = 0; per = 0; g = 0;
    cur = pick(w);
    if (!aligned) begin
      prv = cur; step(); cur = pick(w);
      while (!(cur && !prv) && g < 3000) begin
        prv = cur; step(); cur = pick(w); g++;
      end
    end
    do begin
      per++;
      if (cur) hi++;
      prv = cur; step(); cur = pick(w); g++;
    end while (!(cur && !prv) && g < 6000);
  endtask

  task automatic wr(input logic [15:0] w);
    cfg_we = 1'b1; cfg_wdata = w;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic chk_fast(input string tag);
    repeat (3) begin
      @(posedge clk); #1; chk({tag, " hi phase"}, clk_out, 1);
      @(negedge clk); #1; chk({tag, " lo phase"}, clk_out, 0);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int hi, per, m, p, s;
    logic prv, cur;

    // R9: reset state
    step(); step();
    chk("R9 reset ref_div", ref_div, 0);
    chk("R9 reset fb_div", fb_div, 0);
    chk("R9 reset clk_o", clk_out, 0);
    rst_n = 1'b1;
    step();
    chk("R9 first rise fb", fb_div, 1);
    meas(1, 1'b1, hi, per);
    chk("R9 default main period", per, 8);
    meas(0, 1'b0, hi, per);
    chk("R9 default pre period", per, 2);
    chk_fast("R9 default post");

    // table walk: R1 R2 R3 R4 R5 R10
    for (int i = 0; i < NV; i++) begin
      m = int'(VEC[i][15:8]) + 8;
      p = int'(VEC[i][7:2]) + 2;
      s = int'(VEC[i][1:0]);
      wr(VEC[i]);
      meas(1, 1'b0, hi, per);
      chk($sformatf("R2 R10 fb period v%0d", i), per, m);
      chk($sformatf("R5 fb high v%0d", i), hi, m / 2);
      meas(0, 1'b0, hi, per);
      chk($sformatf("R3 R10 ref period v%0d", i), per, p);
      chk($sformatf("R5 ref high v%0d", i), hi, p / 2);
      if (s == 0) begin
        repeat (10) step();
        chk_fast($sformatf("R4 post pass v%0d", i));
      end else begin
        meas(2, 1'b0, hi, per);
        chk($sformatf("R4 post period v%0d", i), per, 1 << s);
        chk($sformatf("R4 post high v%0d", i), hi, 1 << (s - 1));
      end
    end

    // R6: write mid-period
    wr({8'd20, 6'd0, 2'd1});
    meas(1, 1'b0, hi, per);
    chk("R6 setup fb period", per, 28);
    cur = fb_div;
    do begin prv = cur; step(); cur = fb_div; end while (!(cur && !prv));
    hi = 0; per = 0;
    do begin
      per++;
      if (cur) hi++;
      if (per == 3) begin cfg_we = 1'b1; cfg_wdata = {8'd1, 6'd0, 2'd1}; end
      else cfg_we = 1'b0;
      prv = cur; step(); cur = fb_div;
    end while (!(cur && !prv) && per < 1000);
    cfg_we = 1'b0;
    chk("R6 running period keeps old ratio", per, 28);
    chk("R6 running period old high", hi, 14);
    meas(1, 1'b1, hi, per);
    chk("R6 next period new ratio", per, 9);
    chk("R6 next period new high", hi, 4);

    // R7: per-bit bypass
    test_word = {8'd3, 6'd10, 2'd0};
    test_sel  = 16'hFF00;
    meas(1, 1'b0, hi, per);
    chk("R7 main bypassed", per, 11);
    meas(0, 1'b0, hi, per);
    chk("R7 pre not selected", per, 2);
    test_sel = 16'h00FC;
    meas(0, 1'b0, hi, per);
    chk("R7 pre bypassed", per, 12);
    meas(1, 1'b0, hi, per);
    chk("R7 main back to register", per, 9);
    test_sel = 16'h0000;
    meas(0, 1'b0, hi, per);
    chk("R7 pre back to register", per, 2);

    // R8: power-down
    pwrdn = 1'b1;
    step(); step();
    repeat (3) begin
      @(posedge clk); #1;
      chk("R8 pd ref_div", ref_div, 0);
      chk("R8 pd fb_div", fb_div, 0);
      chk("R8 pd clk_o hi phase", clk_out, 0);
      @(negedge clk); #1;
      chk("R8 pd clk_o lo phase", clk_out, 0);
    end
    step();
    pwrdn = 1'b0;
    step();
    chk("R8 release ref rises", ref_div, 1);
    chk("R8 release fb rises", fb_div, 1);
    chk("R8 release clk_o rises", clk_out, 1);
    meas(1, 1'b1, hi, per);
    chk("R8 first fb period full", per, 9);
    chk("R8 first fb period high", hi, 4);

    finish_run();
  end
endmodule